// File: doc/BRIEF.md
# Stereo Audio Serial Transmit Clock Generator

This block runs entirely from a high-frequency master audio clock. It divides that clock by an integer to make a bit clock, counts bit clocks to make a frame sync, and shifts a stereo sample pair out on one serial data pin. A frame always lasts 64 bit clocks and holds two 32-bit channel words, so the bit clock runs at 64 times the sample rate. The only way to change the sample rate is to change the divider. The divider follows from the ratio of the master clock to the sample rate: a ratio of 128, 256 or 512 needs a divider of 2, 4 or 8. For example, a 24.576 MHz master clock at 48 kHz needs a divider of 8, which gives a 3.072 MHz bit clock.

The line follows I2S timing. The frame sync is low while the left word is sent and high while the right word is sent. Each word goes out MSB first, starting one bit clock after the frame sync edge. Data changes only on the falling edge of the bit clock, so a receiver can sample it on the rising edge.

New sample pairs come in on a parallel left/right port with a valid/ready handshake. The block takes a pair only at a frame boundary. When no pair is offered at that moment, it sends a frame of zeros and sets a sticky underrun flag.

Top module: `stereo_tx_clkgen`

## Requirements
- R1: The bit clock period is D master clock cycles, low for D/2 cycles and then high for D/2 cycles. D comes from `div_sel`: 0 gives 2, 1 gives 4, 2 gives 8, and 3 also gives 8.
- R2: A frame is 64 bit clocks, numbered slot 0 to slot 63. Frame sync is low in slots 0 to 31 and high in slots 32 to 63. The first frame after reset is a left-first frame.
- R3: In slot s (counted from the falling edge of frame sync), the data pin carries:
  - slot 0: bit 0 of the previous frame's right word (0 for the first frame);
  - slots 1 to 32: left word bits 31 down to 0;
  - slots 33 to 63: right word bits 31 down to 1.
- R4: Data and frame sync change only on the master clock edge where the bit clock falls. They hold steady while the bit clock is high.
- R5: `smp_ready` is high for exactly one master clock cycle per frame, in the cycle just before the bit clock falls into slot 0. The pair present while `smp_valid` is high in that cycle is the one sent in that frame.
- R6: If `smp_valid` is low in the ready cycle, that frame carries all-zero words. `underrun` then goes high and stays high until reset.
- R7: A change of `div_sel` during a frame takes effect only from slot 0 of the next frame. Every bit clock phase inside a frame uses that frame's divider.
- R8: While `rst_n` is low, `bclk`, `fsync`, `sdata`, `underrun` and `smp_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 2 | Master-to-bit clock divider select (0:2, 1:4, 2:8, 3:8) |
| smp_left | input | 32 | Left channel word |
| smp_right | input | 32 | Right channel word |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | Frame boundary: the offered pair is taken this cycle |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, low for left and high for right |
| sdata | output | 1 | Serial data, MSB first, changing on bclk fall |
| underrun | output | 1 | Sticky flag: a frame was sent without a valid pair |

## Verification
The hardest case to reach from the ports is a divider change in the middle of a frame. Its effect shows up only as the width of the low phase before each rising edge of the bit clock, and the boundary rule matters only in slot 0 of the next frame. The bench moves `div_sel` at a chosen bit slot and measures every low phase in master clock cycles. The expected width for each slot comes from the frame that slot belongs to. The bench also withholds `smp_valid` for exactly one frame, in varying positions, to confirm that the zero frame appears where expected and that the flag stays set.

// File: rtl/stx_pkg.sv
// Package: shared helpers for the stereo serial transmitter.
// Assumes the divider select maps to a power-of-two half period.
package stx_pkg;

    // Side of the stereo frame currently on the line.
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } stx_side_e;

    // Half bit-clock period (in master cycles) for a divider select code.
    function automatic int unsigned sel_to_half(input int unsigned sel,
                                                input int unsigned max_shift);
        int unsigned sh;
        sh = (sel > max_shift) ? max_shift : sel;
        return 32'd1 << sh;
    endfunction

endpackage

// File: rtl/stx_bclk_gen.sv
// Bit clock generator: divides the master clock by 2*half, with half = 2^sel.
// The divider is sampled at reset and at each frame boundary only, so a
// bit clock phase is never shortened. Assumes frame_end comes from the
// frame sequencer and is stable within a bit slot.
module stx_bclk_gen #(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned MAX_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             frame_end,
    output logic             fall_stb,
    output logic             bclk
);
    localparam int unsigned CNT_W = MAX_SHIFT + 1;

    logic [CNT_W-1:0] half_act;
    logic [CNT_W-1:0] half_sel;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    // Decode the requested half period from the select input.
    always_comb begin
        half_sel = CNT_W'(stx_pkg::sel_to_half(32'(div_sel), MAX_SHIFT));
    end

    // Last count of a full bit clock period, and the fall strobe.
    always_comb begin
        last_cnt = (half_act << 1) - CNT_W'(1);
        fall_stb = (cnt == last_cnt);
    end

    // Count master cycles, shape the bit clock, latch divider at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            bclk     <= 1'b0;
            half_act <= half_sel;
        end else if (fall_stb) begin
            cnt  <= '0;
            bclk <= 1'b0;
            if (frame_end) begin
                half_act <= half_sel;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == half_act - CNT_W'(1)) begin
                bclk <= 1'b1;
            end
        end
    end

    // R1: the counter never runs past the active period.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt);

    // R7: the active divider only moves on a frame-boundary fall.
    p_div_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && frame_end) |=> $stable(half_act));

    // R1: the bit clock rises only after a full low half.
    p_rise_after_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> (cnt == half_act));

endmodule

// File: rtl/stx_frame_seq.sv
// Frame sequencer: counts bit slots 0..2*SLOT_BITS-1 on each bit clock fall
// and drives the frame sync (low = left, high = right). Resets into the last
// slot so the first fall after reset opens a left-first frame.
module stx_frame_seq #(
    parameter int unsigned SLOT_BITS = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 fall_stb,
    output logic [$clog2(2*SLOT_BITS)-1:0]       slot,
    output logic                                 frame_end,
    output logic                                 load_stb,
    output logic                                 fsync
);
    localparam int unsigned FRAME_BITS = 2 * SLOT_BITS;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

    logic [IDX_W-1:0]     next_slot;
    stx_pkg::stx_side_e   next_side;

    // Next slot index and the side that slot belongs to.
    always_comb begin
        frame_end = (slot == IDX_W'(FRAME_BITS - 1));
        next_slot = frame_end ? '0 : slot + IDX_W'(1);
        next_side = (32'(next_slot) >= SLOT_BITS) ? stx_pkg::SIDE_RIGHT
                                                   : stx_pkg::SIDE_LEFT;
        load_stb  = fall_stb && frame_end;
    end

    // Advance the slot and frame sync on each bit clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= IDX_W'(FRAME_BITS - 1);
            fsync <= 1'b0;
        end else if (fall_stb) begin
            slot  <= next_slot;
            fsync <= (next_side == stx_pkg::SIDE_RIGHT);
        end
    end

    // R4: frame sync only moves on a bit clock fall.
    p_fsync_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> $stable(fsync));

    // R2: frame sync rises entering the first right slot.
    p_fsync_rise_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> (slot == IDX_W'(SLOT_BITS)));

endmodule

// File: rtl/stx_shifter.sv
// Serial shifter: holds one frame (left word above right word) and emits its
// MSB on each bit clock fall. At the frame boundary the final bit of the old
// frame goes out while the new pair (or zeros) is loaded, which gives the
// one-bit delay after the frame sync edge.
module stx_shifter #(
    parameter int unsigned SLOT_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall_stb,
    input  logic                 load_stb,
    input  logic                 load_valid,
    input  logic [SLOT_BITS-1:0] left_word,
    input  logic [SLOT_BITS-1:0] right_word,
    output logic                 sdata
);
    localparam int unsigned FRAME_BITS = 2 * SLOT_BITS;

    logic [FRAME_BITS-1:0] sr;

    // Shift out MSB on each fall; reload at frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            sdata <= 1'b0;
        end else if (fall_stb) begin
            sdata <= sr[FRAME_BITS-1];
            if (load_stb) begin
                sr <= load_valid ? {left_word, right_word} : '0;
            end else begin
                sr <= {sr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // R4: serial data only moves on a bit clock fall.
    p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> $stable(sdata));

    // R6: a frame loaded without a valid pair starts all zero.
    p_zero_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !load_valid) |=> (sr == '0));

endmodule

// File: rtl/stereo_tx_clkgen.sv
// Top: stereo serial transmitter with integer bit clock divider and
// I2S-style frame sync. One frame = two SLOT_BITS words on one data pin.
// Assumes an external master clock at 2*2^sel times the bit clock.
module stereo_tx_clkgen #(
    parameter int unsigned SLOT_BITS = 32,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned MAX_SHIFT = 2
) (
    input  logic                 mclk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     div_sel,
    input  logic [SLOT_BITS-1:0] smp_left,
    input  logic [SLOT_BITS-1:0] smp_right,
    input  logic                 smp_valid,
    output logic                 smp_ready,
    output logic                 bclk,
    output logic                 fsync,
    output logic                 sdata,
    output logic                 underrun
);
    localparam int unsigned IDX_W = $clog2(2 * SLOT_BITS);

    logic             fall_stb;
    logic             frame_end;
    logic             load_stb;
    logic [IDX_W-1:0] slot;

    stx_bclk_gen #(
        .SEL_W     (SEL_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_bclk (
        .clk       (mclk),
        .rst_n     (rst_n),
        .div_sel   (div_sel),
        .frame_end (frame_end),
        .fall_stb  (fall_stb),
        .bclk      (bclk)
    );

    stx_frame_seq #(
        .SLOT_BITS (SLOT_BITS)
    ) u_seq (
        .clk       (mclk),
        .rst_n     (rst_n),
        .fall_stb  (fall_stb),
        .slot      (slot),
        .frame_end (frame_end),
        .load_stb  (load_stb),
        .fsync     (fsync)
    );

    stx_shifter #(
        .SLOT_BITS (SLOT_BITS)
    ) u_shift (
        .clk        (mclk),
        .rst_n      (rst_n),
        .fall_stb   (fall_stb),
        .load_stb   (load_stb),
        .load_valid (smp_valid),
        .left_word  (smp_left),
        .right_word (smp_right),
        .sdata      (sdata)
    );

    // Handshake: the frame boundary is the only accept point.
    always_comb begin
        smp_ready = load_stb;
    end

    // Sticky underrun when a boundary passes without a valid pair.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (load_stb && !smp_valid) begin
            underrun <= 1'b1;
        end
    end

    // R5: ready is a single-cycle pulse.
    p_ready_single_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    // R5: ready is followed by the bit clock falling into slot 0.
    p_ready_then_fall_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        smp_ready |=> ($fell(bclk) && (slot == '0)));

    // R6: underrun never clears outside reset.
    p_underrun_sticky_r6: assert property (@(posedge mclk) disable iff (!rst_n)
        underrun |=> underrun);

    // R6: underrun rises only after a boundary with no valid pair.
    p_underrun_cause_r6: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(underrun) |-> $past(smp_ready && !smp_valid));

    // R4: nothing on the line moves while the bit clock stays high.
    p_line_stable_high_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        (bclk && $past(bclk)) |-> ($stable(sdata) && $stable(fsync)));

endmodule

// File: tb/tb_stereo_tx_clkgen.sv
`timescale 1ns/1ps
module tb_stereo_tx_clkgen;
    localparam int NFR = 5;

    logic        mclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  div_sel = '0;
    logic [31:0] smp_left = '0;
    logic [31:0] smp_right = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, bclk, fsync, sdata, underrun;

    int vectors = 0;
    int fails = 0;

    logic [31:0] exp_l [0:NFR];
    logic [31:0] exp_r [0:NFR];

    stereo_tx_clkgen dut (
        .mclk(mclk), .rst_n(rst_n), .div_sel(div_sel),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .bclk(bclk), .fsync(fsync), .sdata(sdata),
        .underrun(underrun)
    );

    always #2 mclk = ~mclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int half_of(input int sel);
        return (sel >= 2) ? 4 : (1 << sel);
    endfunction

    function automatic logic [31:0] gen_l(input int sel, input int f);
        return 32'h8000_0001 ^ (32'(f) * 32'h0123_4567) ^ (32'(sel) << 12);
    endfunction

    function automatic logic [31:0] gen_r(input int sel, input int f);
        return ~gen_l(sel, f) ^ (32'(f) << 20) ^ 32'h0000_0001;
    endfunction

    // One run: start at sel0; at slot index chg (global), switch to sel1;
    // withhold valid for frame gap (-1: never).
    task automatic run_case(input int sel0, input int sel1, input int chg, input int gap);
        int  loaded = 0;
        bit  pend = 0;
        int  k = 0;
        int  lowcnt = 0;
        int  chg_frame = 1000;
        logic pb = 0, ps = 0, pf = 0;
        rst_n = 1'b0;
        div_sel = 2'(sel0);
        smp_valid = 1'b0;
        repeat (3) @(negedge mclk);
        chk("R8 bclk in reset", 32'(bclk), 0);
        chk("R8 fsync in reset", 32'(fsync), 0);
        chk("R8 sdata in reset", 32'(sdata), 0);
        chk("R8 underrun in reset", 32'(underrun), 0);
        chk("R8 ready in reset", 32'(smp_ready), 0);
        rst_n = 1'b1;
        smp_valid = (gap != 0);
        smp_left = gen_l(sel0, 0);
        smp_right = gen_r(sel0, 0);
        forever begin
            @(negedge mclk);
            if (pend) begin
                pend = 0;
                loaded++;
                smp_valid = (loaded != gap);
                smp_left = gen_l(sel0, loaded);
                smp_right = gen_r(sel0, loaded);
            end
            if (smp_ready) begin
                pend = 1;
                exp_l[loaded] = smp_valid ? smp_left : '0;
                exp_r[loaded] = smp_valid ? smp_right : '0;
            end
            if (bclk && pb) begin
                // R4: line stable while the bit clock is high
                chk("R4 sdata stable high", 32'(sdata), 32'(ps));
                chk("R4 fsync stable high", 32'(fsync), 32'(pf));
            end
            if (!bclk) lowcnt++;
            if (bclk && !pb) begin
                k++;
                if (k == 1) begin
                    chk("R2 pre-frame fsync", 32'(fsync), 0);
                    chk("R8 pre-frame sdata", 32'(sdata), 0);
                end else begin
                    int idx = k - 2;
                    int f = idx / 64;
                    int s = idx % 64;
                    int hexp = half_of((f > chg_frame) ? sel1 : sel0);
                    logic eb;
                    if (s == 0) eb = (f == 0) ? 1'b0 : exp_r[f-1][0];
                    else if (s <= 32) eb = exp_l[f][32 - s];
                    else eb = exp_r[f][64 - s];
                    chk("R1/R7 low phase width", 32'(lowcnt), 32'(hexp));
                    chk("R2 fsync side", 32'(fsync), 32'(s >= 32));
                    chk("R3 serial bit", 32'(sdata), 32'(eb));
                    chk("R5 one ready per frame", 32'(loaded), 32'(f + 1));
                    chk("R6 underrun flag", 32'(underrun),
                        32'((gap >= 0) && (gap < loaded)));
                    if (idx == chg) begin
                        div_sel = 2'(sel1);
                        chg_frame = f;
                    end
                    if (idx == NFR * 64 - 1) break;
                end
                lowcnt = 0;
            end
            pb = bclk; ps = sdata; pf = fsync;
        end
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1 sweep over every select code, with underrun positions varied (R6)
        run_case(0, 0, -1, 2);
        run_case(1, 1, -1, -1);
        run_case(2, 2, -1, 0);
        run_case(3, 3, -1, 4);
        // R7 mid-frame divider changes, both directions
        run_case(1, 0, 64 + 10, -1);
        run_case(2, 0, 10, 3);
        run_case(0, 2, 64 * 2 + 40, -1);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule